// File: doc/BRIEF.md
# Command-Framed Serial Peripheral Slave

This block sits in a system clock domain and receives a serial link from a host processor: serial clock, active-low select and a host-to-device data line, and it returns one device-to-host data line. Inside each select frame it treats the first whole byte as a command and every later byte as data. Bits travel least significant first and are sampled on the rising serial clock edge.

A finished command byte is put on a command bus, and a ready line changes level to announce it. An internal decoder sees that change and raises one select line per known command. Command bit 7 sets the direction. In a write frame each later byte appears on a write data bus. In a read frame the block sends the parallel read word to the host. After every data byte the block gives a single-cycle increment strobe, so an outside address pointer can step through a burst.

Top module: `spi_cmd_slave`

## Requirements
- R1: After synchronous reset, miso, cmd_bus, cmd_rdy, cmd_sel, wr_data and auto_inc are all zero.
- R2: mosi is sampled on each rising sclk edge while cs_n is low, bit 0 first. The first complete byte of a frame appears on cmd_bus.
- R3: A command whose bits 6:0 hold a value below NUM_CMDS raises only cmd_sel bit [value]. Any other command raises no line. Bit 7 has no effect on the choice. cmd_sel clears when cs_n returns high.
- R4: In a frame whose command has bit 7 = 0, each later byte appears on wr_data while auto_inc is high.
- R5: In a frame whose command has bit 7 = 1, each data byte is sent on miso, bit 0 first, and holds each bit while sclk rises. Data byte k carries the rd_word value sampled after the k-th auto_inc pulse of the frame, counting from zero, so byte 0 uses the value present right after the command. In write frames miso stays 0.
- R6: auto_inc is high for exactly one clk cycle after each data byte. The command byte produces no pulse.
- R7: If cs_n rises before a byte has all 8 bits, that partial byte is dropped and gives no pulse. The next frame again starts with a command byte.
- R8: cmd_rdy changes level once for every command byte, including a repeat of the same value. cmd_bus changes only together with cmd_rdy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x sclk |
| rst | input | 1 | Synchronous reset, active high |
| sclk | input | 1 | Serial clock from host |
| cs_n | input | 1 | Frame select, active low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| cmd_bus | output | 8 | Last command byte received |
| cmd_rdy | output | 1 | Level changes once per command byte |
| cmd_sel | output | NUM_CMDS | One-hot command decode |
| wr_data | output | 8 | Data byte of a write frame |
| auto_inc | output | 1 | One-cycle strobe after each data byte |
| rd_word | input | 8 | Parallel word to send to host |

## Verification
The bench sends the same command twice in a row. A design that pulses cmd_rdy instead of toggling it, or that toggles only when the value changes, leaves cmd_rdy at the same level. Frames are cut short in the middle of both a command byte and a data byte. A design that keeps a partial byte shows a spurious strobe or a misaligned command in the next frame. Read bursts check each byte against the pointer-driven word. A design that loads rd_word before the strobe takes effect repeats a byte. Commands with bit 7 set, and values outside the decoded range, show any decoder that ignores the direction bit or lights a line for an unknown command.

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave #(
  parameter int NUM_CMDS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sclk,
  input  logic                cs_n,
  input  logic                mosi,
  output logic                miso,
  output logic [7:0]          cmd_bus,
  output logic                cmd_rdy,
  output logic [NUM_CMDS-1:0] cmd_sel,
  output logic [7:0]          wr_data,
  output logic                auto_inc,
  input  logic [7:0]          rd_word
);

  logic [2:0] sck_s, cs_s;
  logic [1:0] mo_s;
  logic [2:0] bitcnt;
  logic [7:0] rx, tx;
  logic       in_cmd, rd_mode, ld, rdy_seen;

  wire sel      = ~cs_s[1];
  wire sck_rise = sck_s[1] & ~sck_s[2];
  wire cs_fall  = ~cs_s[1] & cs_s[2];
  wire cs_rise  = cs_s[1] & ~cs_s[2];
  wire [7:0] byte_in = {mo_s[1], rx[7:1]};
  wire [NUM_CMDS-1:0] dec =
    (32'(cmd_bus[6:0]) < NUM_CMDS) ? NUM_CMDS'(1) << cmd_bus[6:0] : '0;

  assign miso = tx[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_s <= '0;
      cs_s  <= '1;
      mo_s  <= '0;
    end else begin
      sck_s <= {sck_s[1:0], sclk};
      cs_s  <= {cs_s[1:0], cs_n};
      mo_s  <= {mo_s[0], mosi};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bitcnt   <= '0;
      rx       <= '0;
      tx       <= '0;
      in_cmd   <= 1'b1;
      rd_mode  <= 1'b0;
      ld       <= 1'b0;
      cmd_bus  <= '0;
      cmd_rdy  <= 1'b0;
      wr_data  <= '0;
      auto_inc <= 1'b0;
    end else begin
      auto_inc <= 1'b0;
      ld       <= auto_inc & rd_mode;
      if (ld) tx <= rd_word;
      if (cs_fall) begin
        bitcnt  <= '0;
        in_cmd  <= 1'b1;
        rd_mode <= 1'b0;
        tx      <= '0;
      end else if (sel && sck_rise) begin
        rx     <= byte_in;
        bitcnt <= bitcnt + 3'd1;
        tx     <= tx >> 1;
        if (bitcnt == 3'd7) begin
          if (in_cmd) begin
            cmd_bus <= byte_in;
            cmd_rdy <= ~cmd_rdy;
            in_cmd  <= 1'b0;
            rd_mode <= byte_in[7];
            ld      <= byte_in[7];
          end else begin
            auto_inc <= 1'b1;
            if (!rd_mode) wr_data <= byte_in;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_seen <= 1'b0;
      cmd_sel  <= '0;
    end else begin
      rdy_seen <= cmd_rdy;
      if (cs_rise) cmd_sel <= '0;
      else if (rdy_seen != cmd_rdy) cmd_sel <= dec;
    end
  end

  a_r6_inc_single: assert property (@(posedge clk) disable iff (rst)
    auto_inc |=> !auto_inc);

  a_r3_sel_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmd_sel));

  a_r8_cmd_with_rdy: assert property (@(posedge clk) disable iff (rst)
    !$stable(cmd_bus) |-> !$stable(cmd_rdy));

  a_r7_inc_in_frame: assert property (@(posedge clk) disable iff (rst)
    auto_inc |-> !$past(cs_s[1]));

  a_r3_sel_after_rdy: assert property (@(posedge clk) disable iff (rst)
    (cmd_sel != '0 && $past(cmd_sel) == '0) |-> $past(rdy_seen != cmd_rdy));

endmodule

// File: tb/spi_cmd_slave_tb.sv
module spi_cmd_slave_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1, sclk = 0, cs_n = 1, mosi = 0;
  logic miso, cmd_rdy, auto_inc;
  logic [7:0] cmd_bus, wr_data, rd_word;
  logic [7:0] cmd_sel;

  int checks = 0, errors = 0;
  int ptr = 0, ncap = 0, run = 0;
  bit long_pulse = 0;
  logic [7:0] cap [16];
  logic [7:0] txb [8];
  logic [7:0] rxb [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] word_at(int p);
    return 8'(p * 29 + 7);
  endfunction

  function automatic logic [7:0] exp_sel(logic [7:0] c);
    return (c[6:0] < 7'd8) ? 8'(1 << c[2:0]) : 8'h00;
  endfunction

  assign rd_word = word_at(ptr);

  spi_cmd_slave #(.NUM_CMDS(8)) u_dut (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .cmd_bus(cmd_bus), .cmd_rdy(cmd_rdy), .cmd_sel(cmd_sel),
    .wr_data(wr_data), .auto_inc(auto_inc), .rd_word(rd_word));

  always @(posedge clk) begin
    if (auto_inc) begin
      if (ncap < 16) cap[ncap] = wr_data;
      ncap = ncap + 1;
      ptr <= ptr + 1;
      run = run + 1;
      if (run > 1) long_pulse = 1;
    end else run = 0;
  end

  task automatic check(bit ok, string msg, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", msg, act, exp);
    end
  endtask

  task automatic send_bits(input logic [7:0] v, input int nb, output logic [7:0] got);
    got = 8'h00;
    for (int i = 0; i < nb; i++) begin
      mosi = v[i];
      repeat (4) @(negedge clk);
      got[i] = miso;
      sclk = 1;
      repeat (4) @(negedge clk);
      sclk = 0;
    end
  endtask

  task automatic do_frame(input logic [7:0] cmd, input int n);
    logic r0;
    int p0;
    logic [7:0] b;
    r0 = cmd_rdy;
    ncap = 0;
    p0 = ptr;
    cs_n = 0;
    repeat (4) @(negedge clk);
    send_bits(cmd, 8, b);
    repeat (4) @(negedge clk);
    check(cmd_bus == cmd, "R2 cmd_bus", cmd_bus, cmd);
    check(cmd_rdy != r0, "R8 rdy toggle", cmd_rdy, !r0);
    check(cmd_sel == exp_sel(cmd), "R3 decode", cmd_sel, exp_sel(cmd));
    check(ncap == 0, "R6 no strobe for command", ncap, 0);
    for (int k = 0; k < n; k++) send_bits(txb[k], 8, rxb[k]);
    repeat (4) @(negedge clk);
    check(ncap == n, "R6 strobe count", ncap, n);
    for (int k = 0; k < n; k++) begin
      if (cmd[7]) check(rxb[k] == word_at(p0 + k), "R5 read byte", rxb[k], word_at(p0 + k));
      else begin
        check(cap[k] == txb[k], "R4 write byte", cap[k], txb[k]);
        check(rxb[k] == 8'h00, "R5 miso idle in write", rxb[k], 0);
      end
    end
    cs_n = 1;
    repeat (6) @(negedge clk);
    check(cmd_sel == 8'h00, "R3 cleared at frame end", cmd_sel, 0);
  endtask

  initial begin
    logic [7:0] b;
    logic [7:0] c;
    logic r0;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);
    check(miso == 0 && auto_inc == 0 && cmd_rdy == 0, "R1 reset outputs",
          {miso, auto_inc, cmd_rdy}, 0);
    check(cmd_bus == 0 && wr_data == 0 && cmd_sel == 0, "R1 reset buses",
          cmd_bus | wr_data | cmd_sel, 0);

    txb[0] = 8'hA5; txb[1] = 8'h3C; txb[2] = 8'hFF;
    do_frame(8'h02, 3);
    do_frame(8'h85, 4);
    do_frame(8'h85, 2);
    do_frame(8'h4A, 1);
    do_frame(8'h07, 0);

    // R7: partial data byte
    cs_n = 0; ncap = 0;
    repeat (4) @(negedge clk);
    send_bits(8'h01, 8, b);
    send_bits(8'h55, 3, b);
    cs_n = 1;
    repeat (8) @(negedge clk);
    check(ncap == 0, "R7 partial data byte no strobe", ncap, 0);
    // R7: partial command byte
    r0 = cmd_rdy;
    cs_n = 0;
    repeat (4) @(negedge clk);
    send_bits(8'h03, 5, b);
    cs_n = 1;
    repeat (8) @(negedge clk);
    check(cmd_rdy == r0, "R7 partial command dropped", cmd_rdy, r0);
    check(cmd_bus == 8'h01, "R7 cmd_bus unchanged", cmd_bus, 8'h01);
    txb[0] = 8'h96;
    do_frame(8'h04, 1);

    for (int f = 0; f < 20; f++) begin
      c = 8'($urandom);
      if ($urandom % 4 != 0) c[6:0] = 7'($urandom % 8);
      for (int k = 0; k < 8; k++) txb[k] = 8'($urandom);
      do_frame(c, int'($urandom % 5));
    end

    check(!long_pulse, "R6 pulse width one cycle", long_pulse, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog act=1 exp=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule